// File: doc/BRIEF.md
# NAND Redundant Boot-Copy Sequencer

This block runs once after reset and pulls a bootstrap image out of a raw NAND device into an on-chip boot buffer. It first waits for the device to report ready, issues the device reset command, and then reads a burst of consecutive pages from the first copy of the image, streaming every byte to a buffer write port. After each page it samples a pass/fail flag from an external ECC checker. A clean burst ends the sequence with success. A failing page abandons that copy and restarts the whole burst at the next redundant copy, which sits a fixed number of pages further into the device.

The device side is a simplified byte-wide handshake: a command strobe, an address strobe, a read strobe, one outgoing byte, one incoming byte and a ready/busy flag. The sequencer issues one command or address byte per cycle and reads one data byte per cycle while the device is ready. When every copy has failed, the block stops with a failure flag and stays silent on both the device and buffer sides until the next reset.

Top module: `nand_boot_seq`

## Requirements
- R1: While reset is asserted and after it is released until the first command, done, boot_ok, boot_fail, nf_cle, nf_ale, nf_re and buf_we are all 0; a reset during a running boot aborts it and the next boot starts over from the beginning.
- R2: The first command byte presented (nf_cle high) after reset is 0xFF, and it is not presented before nf_rdy has been seen high; it is issued exactly once per boot.
- R3: Each page read is presented as: one nf_cle cycle with 0x00, five consecutive nf_ale cycles carrying column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, row bits 23:16 (least significant byte first, column always 0), then one nf_cle cycle with 0x30; nf_cle and nf_ale are never high together.
- R4: The row of page p of copy c is c*256 + p, with p counting 0 to 3 and copies tried in the order 0, 256, 512, 768.
- R5: After every command the sequencer waits for nf_rdy high before reading, and nf_re is only high while nf_rdy is high.
- R6: Data bytes are written to the buffer at consecutive addresses page*PAGE_BYTES + byte, so a passing copy leaves its 4 pages contiguous from address 0.
- R7: An ECC failure (ecc_valid and ecc_fail high while a page's result is awaited) ends the current copy at once: no further page of that copy is read, and the next copy writes the buffer again from address 0.
- R8: When all 4 pages of a copy pass, done and boot_ok go high and copy_idx holds that copy's index (0 to 3).
- R9: When the fourth copy fails, done and boot_fail go high, copy_idx is 3, and nf_cle, nf_ale, nf_re and buf_we stay low from then on.
- R10: Once done is high, done, boot_ok, boot_fail and copy_idx hold their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nf_rdy | input | 1 | Device ready (1) / busy (0) |
| nf_din | input | 8 | Data byte from the device, valid while nf_re is high |
| ecc_valid | input | 1 | ECC result for the page just read is available |
| ecc_fail | input | 1 | ECC result: 1 means the page is uncorrectable |
| nf_cle | output | 1 | Command byte strobe |
| nf_ale | output | 1 | Address byte strobe |
| nf_re | output | 1 | Read one data byte this cycle |
| nf_dout | output | 8 | Command or address byte to the device |
| buf_we | output | 1 | Boot buffer write enable |
| buf_addr | output | AW | Boot buffer write address |
| buf_wdata | output | 8 | Boot buffer write data |
| done | output | 1 | Sequence finished |
| boot_ok | output | 1 | A copy passed |
| boot_fail | output | 1 | All copies failed |
| copy_idx | output | CPW | Index of the copy being read or that gave the result |

## Verification
The ECC verdict on the last page of a copy lands in the same cycle as the decision to end the sequence, so a pass and an abandon compete there. Fail patterns that mark only the fourth page of a copy provoke this, on an early copy and on the last one; the bench judges it by whether done rises, by the next row address seen on the address strobe, and by whether the buffer is refilled from address 0. A failure on the last page of the last copy must produce boot_fail rather than boot_ok.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam logic [7:0] NBS_CMD_RESET  = 8'hFF;
    localparam logic [7:0] NBS_CMD_READ_A = 8'h00;
    localparam logic [7:0] NBS_CMD_READ_B = 8'h30;
    localparam int         NBS_ADDR_CYC   = 5;
    localparam int         NBS_ROW_W      = 24;

    typedef enum logic [3:0] {
        S_PWR_WAIT,
        S_RST_CMD,
        S_RST_SETTLE,
        S_RST_WAIT,
        S_RD_CMD0,
        S_RD_ADDR,
        S_RD_CMD1,
        S_RD_SETTLE,
        S_RD_WAIT,
        S_RD_DATA,
        S_ECC,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        IO_IDLE,
        IO_CMD,
        IO_ADDR
    } io_sel_e;

endpackage

// File: rtl/nbs_addr_gen.sv
module nbs_addr_gen import nbs_pkg::*; #(
    parameter int PGW         = 2,
    parameter int CPW         = 2,
    parameter int COPY_STRIDE = 256
) (
    input  logic [CPW-1:0] copy,
    input  logic [PGW-1:0] page,
    input  logic [2:0]     step,
    output logic [7:0]     addr_byte
);
    logic [NBS_ROW_W-1:0] row;

    always_comb begin
        row = NBS_ROW_W'(copy) * NBS_ROW_W'(COPY_STRIDE) + NBS_ROW_W'(page);
    end

    // column bytes first, then row bytes, least significant first
    always_comb begin
        case (step)
            3'd0:    addr_byte = 8'h00;
            3'd1:    addr_byte = 8'h00;
            3'd2:    addr_byte = row[7:0];
            3'd3:    addr_byte = row[15:8];
            3'd4:    addr_byte = row[23:16];
            default: addr_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/nbs_io_mux.sv
module nbs_io_mux import nbs_pkg::*; (
    input  io_sel_e    sel,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] addr_byte,
    output logic       cle,
    output logic       ale,
    output logic [7:0] dout
);
    always_comb begin
        cle  = 1'b0;
        ale  = 1'b0;
        dout = 8'h00;
        case (sel)
            IO_CMD: begin
                cle  = 1'b1;
                dout = cmd_byte;
            end
            IO_ADDR: begin
                ale  = 1'b1;
                dout = addr_byte;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_boot_seq.sv
module nand_boot_seq import nbs_pkg::*; #(
    parameter int  PAGE_BYTES     = 16,
    parameter int  PAGES_PER_COPY = 4,
    parameter int  NUM_COPIES     = 4,
    parameter int  COPY_STRIDE    = 256,
    localparam int AW  = $clog2(PAGE_BYTES * PAGES_PER_COPY),
    localparam int CPW = $clog2(NUM_COPIES > 1 ? NUM_COPIES : 2),
    localparam int PGW = $clog2(PAGES_PER_COPY > 1 ? PAGES_PER_COPY : 2),
    localparam int BCW = $clog2(PAGE_BYTES > 1 ? PAGE_BYTES : 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           nf_rdy,
    input  logic [7:0]     nf_din,
    input  logic           ecc_valid,
    input  logic           ecc_fail,
    output logic           nf_cle,
    output logic           nf_ale,
    output logic           nf_re,
    output logic [7:0]     nf_dout,
    output logic           buf_we,
    output logic [AW-1:0]  buf_addr,
    output logic [7:0]     buf_wdata,
    output logic           done,
    output logic           boot_ok,
    output logic           boot_fail,
    output logic [CPW-1:0] copy_idx
);
    localparam logic [CPW-1:0] LAST_COPY = CPW'(NUM_COPIES - 1);
    localparam logic [PGW-1:0] LAST_PAGE = PGW'(PAGES_PER_COPY - 1);
    localparam logic [BCW-1:0] LAST_BYTE = BCW'(PAGE_BYTES - 1);

    typedef struct packed {
        seq_state_e     st;
        logic [2:0]     step;
        logic [PGW-1:0] page;
        logic [CPW-1:0] copy;
        logic [BCW-1:0] bcnt;
        logic [AW-1:0]  ptr;
        logic           we;
        logic [AW-1:0]  waddr;
        logic [7:0]     wdata;
        logic           ok;
        logic           fail;
    } seq_t;

    seq_t       q, d;
    io_sel_e    io_sel;
    logic [7:0] cmd_byte;
    logic [7:0] addr_byte;
    logic       re_d;

    nbs_addr_gen #(
        .PGW         (PGW),
        .CPW         (CPW),
        .COPY_STRIDE (COPY_STRIDE)
    ) u_addr (
        .copy      (q.copy),
        .page      (q.page),
        .step      (q.step),
        .addr_byte (addr_byte)
    );

    nbs_io_mux u_io (
        .sel       (io_sel),
        .cmd_byte  (cmd_byte),
        .addr_byte (addr_byte),
        .cle       (nf_cle),
        .ale       (nf_ale),
        .dout      (nf_dout)
    );

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        io_sel   = IO_IDLE;
        cmd_byte = 8'h00;
        re_d     = 1'b0;
        case (q.st)
            S_PWR_WAIT: begin
                if (nf_rdy) d.st = S_RST_CMD;
            end
            S_RST_CMD: begin
                io_sel   = IO_CMD;
                cmd_byte = NBS_CMD_RESET;
                d.st     = S_RST_SETTLE;
            end
            S_RST_SETTLE: begin
                d.st = S_RST_WAIT;
            end
            S_RST_WAIT: begin
                if (nf_rdy) begin
                    d.st   = S_RD_CMD0;
                    d.copy = '0;
                    d.page = '0;
                    d.ptr  = '0;
                end
            end
            S_RD_CMD0: begin
                io_sel   = IO_CMD;
                cmd_byte = NBS_CMD_READ_A;
                d.step   = 3'd0;
                d.st     = S_RD_ADDR;
            end
            S_RD_ADDR: begin
                io_sel = IO_ADDR;
                if (q.step == 3'(NBS_ADDR_CYC - 1)) begin
                    d.step = 3'd0;
                    d.st   = S_RD_CMD1;
                end else begin
                    d.step = q.step + 3'd1;
                end
            end
            S_RD_CMD1: begin
                io_sel   = IO_CMD;
                cmd_byte = NBS_CMD_READ_B;
                d.st     = S_RD_SETTLE;
            end
            S_RD_SETTLE: begin
                d.st = S_RD_WAIT;
            end
            S_RD_WAIT: begin
                if (nf_rdy) begin
                    d.bcnt = '0;
                    d.st   = S_RD_DATA;
                end
            end
            S_RD_DATA: begin
                if (nf_rdy) begin
                    re_d    = 1'b1;
                    d.we    = 1'b1;
                    d.waddr = q.ptr;
                    d.wdata = nf_din;
                    d.ptr   = q.ptr + 1'b1;
                    if (q.bcnt == LAST_BYTE) begin
                        d.st = S_ECC;
                    end else begin
                        d.bcnt = q.bcnt + 1'b1;
                    end
                end
            end
            S_ECC: begin
                if (ecc_valid) begin
                    if (ecc_fail) begin
                        if (q.copy == LAST_COPY) begin
                            d.fail = 1'b1;
                            d.st   = S_DONE;
                        end else begin
                            d.copy = q.copy + 1'b1;
                            d.page = '0;
                            d.ptr  = '0;
                            d.st   = S_RD_CMD0;
                        end
                    end else if (q.page == LAST_PAGE) begin
                        d.ok = 1'b1;
                        d.st = S_DONE;
                    end else begin
                        d.page = q.page + 1'b1;
                        d.st   = S_RD_CMD0;
                    end
                end
            end
            S_DONE: ;
            default: d.st = S_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_PWR_WAIT, step: '0, page: '0, copy: '0, bcnt: '0,
                   ptr: '0, we: 1'b0, waddr: '0, wdata: '0, ok: 1'b0,
                   fail: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign nf_re     = re_d;
    assign buf_we    = q.we;
    assign buf_addr  = q.waddr;
    assign buf_wdata = q.wdata;
    assign done      = (q.st == S_DONE);
    assign boot_ok   = q.ok;
    assign boot_fail = q.fail;
    assign copy_idx  = q.copy;

    // records whether any command has gone out since reset
    logic cmd_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmd_seen_q <= 1'b0;
        else if (nf_cle) cmd_seen_q <= 1'b1;
    end

    AST_FIRST_CMD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_cle && !cmd_seen_q) |-> (nf_dout == NBS_CMD_RESET)); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale)); // R3
    AST_READ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        nf_re |-> nf_rdy); // R5
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (boot_ok != boot_fail)); // R8
    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        boot_fail |-> !(nf_cle || nf_ale || nf_re || buf_we)); // R9
    AST_FAIL_LAST_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_fail |-> (copy_idx == LAST_COPY)); // R9
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(copy_idx) && $stable(boot_ok) && $stable(boot_fail))); // R10
endmodule

// File: tb/nand_boot_seq_test.sv
`timescale 1ns/1ps
module nand_boot_seq_test;
    localparam int PB = 16;
    localparam int NP = 4;

    typedef struct packed {
        logic [15:0] mask;
        logic        ok;
        logic [1:0]  cp;
        logic [4:0]  npages;
    } vec_t;

    // mask bit (copy*4 + page) = 1 marks that page as an ECC failure
    localparam vec_t VECS [7] = '{
        '{16'h0000, 1'b1, 2'd0, 5'd4},
        '{16'h0001, 1'b1, 2'd1, 5'd5},
        '{16'h0008, 1'b1, 2'd1, 5'd8},
        '{16'h0088, 1'b1, 2'd2, 5'd12},
        '{16'h0421, 1'b1, 2'd3, 5'd10},
        '{16'h8421, 1'b0, 2'd3, 5'd10},
        '{16'h1111, 1'b0, 2'd3, 5'd4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nf_rdy;
    logic [7:0] nf_din;
    logic       ecc_valid;
    logic       ecc_fail;
    logic       nf_cle, nf_ale, nf_re;
    logic [7:0] nf_dout;
    logic       buf_we;
    logic [5:0] buf_addr;
    logic [7:0] buf_wdata;
    logic       done, boot_ok, boot_fail;
    logic [1:0] copy_idx;

    always #2.5 clk = ~clk;

    nand_boot_seq uut (
        .clk(clk), .rst_n(rst_n), .nf_rdy(nf_rdy), .nf_din(nf_din),
        .ecc_valid(ecc_valid), .ecc_fail(ecc_fail), .nf_cle(nf_cle),
        .nf_ale(nf_ale), .nf_re(nf_re), .nf_dout(nf_dout), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .done(done),
        .boot_ok(boot_ok), .boot_fail(boot_fail), .copy_idx(copy_idx)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    function automatic logic [7:0] dat(input logic [23:0] row, input int col);
        return {row[9:8], row[1:0], 4'b0000} ^ 8'(col);
    endfunction

    // ---------------- device model ----------------
    logic [15:0] fail_mask = '0;
    int          pwr_busy = 3;
    int          busy_cnt;
    logic [7:0]  abyte [5];
    int          acnt;
    logic [7:0]  last_cmd;
    logic [23:0] cur_row;
    int          col_q;
    logic [23:0] rows_log [32];
    int          nrows, reset_cnt, proto_err, col_err, re_busy, late_act;
    int          since_rst, first_cmd_cyc;
    logic [7:0]  first_cmd;
    logic        first_rdy, cmd_seen;
    logic [7:0]  bmem [64];

    assign nf_rdy    = (busy_cnt == 0);
    assign nf_din    = dat(cur_row, col_q);
    assign ecc_valid = 1'b1;
    assign ecc_fail  = fail_mask[{cur_row[9:8], cur_row[1:0]}];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            busy_cnt <= pwr_busy;
            acnt <= 0; last_cmd <= 8'h55; cur_row <= '0; col_q <= 0;
            nrows <= 0; reset_cnt <= 0; proto_err <= 0; col_err <= 0;
            re_busy <= 0; late_act <= 0; since_rst <= 0; first_cmd_cyc <= -1;
            first_cmd <= 8'h00; first_rdy <= 1'b0; cmd_seen <= 1'b0;
        end else begin
            since_rst <= since_rst + 1;
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (nf_cle) begin
                if (!cmd_seen) begin
                    cmd_seen <= 1'b1; first_cmd <= nf_dout;
                    first_rdy <= nf_rdy; first_cmd_cyc <= since_rst;
                end
                last_cmd <= nf_dout;
                if (nf_dout == 8'hFF) begin
                    reset_cnt <= reset_cnt + 1; busy_cnt <= 8;
                end else if (nf_dout == 8'h00) begin
                    acnt <= 0;
                end else if (nf_dout == 8'h30) begin
                    if (acnt != 5 || last_cmd != 8'h00) proto_err <= proto_err + 1;
                    if (abyte[0] != 8'h00 || abyte[1] != 8'h00) col_err <= col_err + 1;
                    cur_row <= {abyte[4], abyte[3], abyte[2]};
                    if (nrows < 32) rows_log[nrows] <= {abyte[4], abyte[3], abyte[2]};
                    nrows <= nrows + 1;
                    col_q <= 0;
                    busy_cnt <= 5;
                end else begin
                    proto_err <= proto_err + 1;
                end
            end
            if (nf_ale) begin
                if (acnt < 5) abyte[acnt] <= nf_dout;
                else proto_err <= proto_err + 1;
                acnt <= acnt + 1;
            end
            if (nf_cle && nf_ale) proto_err <= proto_err + 1;
            if (nf_re) begin
                col_q <= col_q + 1;
                if (busy_cnt != 0) re_busy <= re_busy + 1;
            end
            if (done && (nf_cle || nf_ale || nf_re || buf_we)) late_act <= late_act + 1;
        end
        if (buf_we) bmem[buf_addr] <= buf_wdata;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_reset(input int busy);
        pwr_busy = busy;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) bmem[i] = 8'hEE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done(output bit ok);
        int n = 0;
        ok = 1'b0;
        while (n < 5000) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
            n++;
        end
    endtask

    task automatic run_vec(input vec_t v, input int busy);
        bit got;
        logic [23:0] exp_rows [32];
        int ne = 0;
        bit stop = 0;
        bit rows_ok = 1;
        int bad_buf = 0;
        fail_mask = v.mask;
        for (int c = 0; c < 4 && !stop; c++) begin
            for (int p = 0; p < NP; p++) begin
                exp_rows[ne] = 24'(c * 256 + p);
                ne++;
                if (v.mask[c*4 + p]) break;
                if (p == NP - 1) stop = 1;
            end
        end
        apply_reset(busy);
        wait_done(got);
        chk(got, "R8", "done reached", int'(got), 1);
        repeat (20) @(negedge clk);
        chk(done == 1'b1, "R10", "done held", int'(done), 1);
        chk(boot_ok == v.ok, "R8", "boot_ok", int'(boot_ok), int'(v.ok));
        chk(boot_fail == !v.ok, "R9", "boot_fail", int'(boot_fail), int'(!v.ok));
        chk(copy_idx == v.cp, "R8", "copy_idx", int'(copy_idx), int'(v.cp));
        chk(nrows == int'(v.npages), "R7", "pages read", nrows, int'(v.npages));
        for (int i = 0; i < ne && i < nrows && i < 32; i++)
            if (rows_log[i] != exp_rows[i]) rows_ok = 0;
        chk(rows_ok, "R4", "row sequence", int'(rows_ok), 1);
        chk(proto_err == 0, "R3", "read command framing errors", proto_err, 0);
        chk(col_err == 0, "R3", "nonzero column", col_err, 0);
        chk(reset_cnt == 1 && first_cmd == 8'hFF, "R2", "reset cmd first/once",
            int'(first_cmd), 255);
        chk(first_rdy == 1'b1, "R2", "ready before first cmd", int'(first_rdy), 1);
        chk(re_busy == 0, "R5", "reads while busy", re_busy, 0);
        chk(late_act == 0, "R9", "activity after done", late_act, 0);
        if (v.ok) begin
            for (int i = 0; i < 64; i++)
                if (bmem[i] != dat(24'(int'(v.cp) * 256 + i / PB), i % PB))
                    bad_buf++;
            chk(bad_buf == 0, "R6", "buffer bytes wrong (R7 restart)", bad_buf, 0);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        while (cycles < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        bit got;
        // reset state, R1
        pwr_busy = 3;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done && !boot_ok && !boot_fail, "R1", "status in reset",
            int'({done, boot_ok, boot_fail}), 0);
        chk(!nf_cle && !nf_ale && !nf_re && !buf_we, "R1", "strobes in reset",
            int'({nf_cle, nf_ale, nf_re, buf_we}), 0);

        // table of fail patterns
        for (int k = 0; k < 7; k++) run_vec(VECS[k], 3);

        // long power-up busy: first command must wait, R2
        run_vec(VECS[0], 40);
        chk(first_cmd_cyc >= 40, "R2", "first cmd cycle after long busy",
            first_cmd_cyc, 40);

        // reset in the middle of a boot, R1
        fail_mask = 16'h0001;
        apply_reset(3);
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!done && !nf_cle && !nf_ale && !nf_re, "R1", "abort on reset",
            int'({done, nf_cle, nf_ale, nf_re}), 0);
        run_vec(VECS[2], 3);

        // fail on last page of last copy only after three clean-early failures, R9
        run_vec('{16'h8111, 1'b0, 2'd3, 5'd7}, 3);
        got = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule